// File: doc/BRIEF.md
# Wave Issue Scheduler

This block picks which wavefronts issue an instruction on each clock of a compute unit that has several SIMDs, each with a fixed number of wave slots. It steps through the SIMDs one per cycle in rotation. On the SIMD in focus it looks at the slots that hold a wave with a ready instruction, and grants at most one wave per functional category. The categories are vector ALU (matrix multiply-add is issued here too), scalar ALU, scratchpad, vector memory and branch.

Instructions marked as internal use no functional unit. Every ready internal instruction on the focused SIMD issues, and none of them counts against the category limit. A unit that is busy can stop issue to its category for a cycle. Within each SIMD and category, a rotating start pointer shares the grants fairly among the slots. Grants and category strobes are registered and appear one cycle after the inputs are sampled.

Top module: `wave_issue_sched`

## Requirements
- R1: While reset is high, at the next edge every bit of `issue_grant` and `cat_issue` goes to 0. The SIMD pointer returns to SIMD 0 and every category start pointer returns to slot 0.
- R2: The first clock edge after reset is released considers SIMD 0, the next edge SIMD 1, and so on, wrapping after the last SIMD. The grants decided at an edge are visible on the outputs from that edge on, and they lie only within the SIMD considered at that edge.
- R3: Wave slot j of SIMD s is bit s*WAVES_PER_SIMD+j of `slot_valid`, `slot_ready` and `issue_grant`, and its code is bits [3*(s*WAVES_PER_SIMD+j) +: 3] of `slot_cat`. A slot can be granted only when both its valid and ready bits are 1, and slots on other SIMDs have no effect.
- R4: Category codes are 0 vector ALU, 1 scalar ALU, 2 scratchpad, 3 vector memory and 4 branch. At most one slot with a given code is granted per cycle. Bit c of `cat_issue` is 1 exactly when a slot with code c was granted.
- R5: For each SIMD and category the search starts at a stored slot pointer and moves upward with wrap-around. After a grant, that pointer becomes the winner's slot plus 1, modulo the slot count.
- R6: When bit c of `cat_busy` is 1 at an edge, no slot with code c is granted at that edge, and that category's pointer stays unchanged.
- R7: Every eligible slot with code 5 (internal) on the considered SIMD is granted at the same edge. No `cat_issue` bit rises for it and no pointer moves.
- R8: Slots with code 6 or 7 are never granted.
- R9: One cycle can grant a winner in all five categories plus any number of internal slots. Each slot receives at most one grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | NUM_SIMD*WAVES_PER_SIMD | Slot holds a wave |
| slot_ready | input | NUM_SIMD*WAVES_PER_SIMD | Slot's next instruction may issue |
| slot_cat | input | 3*NUM_SIMD*WAVES_PER_SIMD | Category code per slot |
| cat_busy | input | 5 | Category unit cannot accept this cycle |
| issue_grant | output | NUM_SIMD*WAVES_PER_SIMD | Registered per-slot issue grant |
| cat_issue | output | 5 | Registered per-category issue strobe |

## Verification
The bench keeps an independent model of the SIMD rotation and of every per-SIMD, per-category pointer, and compares both outputs against it on every cycle. The stimulus mixes slot patterns that include the unused codes, internal instructions and busy categories. The corner cases it targets are these:
- A single category that is ready on every slot of every SIMD. A pointer that fails to advance, or that is shared across SIMDs, grants the wrong slot.
- All categories busy. A design that ignores busy strobes a unit.
- Internal slots. A design that limits them to one, or that counts them as vector ALU, is caught.
- Codes 6 and 7. A design that treats them as categories grants them.
- A full five-category-plus-internal cycle, which catches a per-cycle issue cap.
- A reset in mid-run, which must bring the rotation and the pointers back to SIMD 0, slot 0.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int CAT_W   = 3;
  localparam int NUM_CAT = 5;

  typedef enum logic [CAT_W-1:0] {
    CAT_VALU     = 3'd0,
    CAT_SALU     = 3'd1,
    CAT_SCRATCH  = 3'd2,
    CAT_VMEM     = 3'd3,
    CAT_BRANCH   = 3'd4,
    CAT_INTERNAL = 3'd5
  } cat_e;

  // Resolution order: branch, scalar, vector memory, scratchpad, vector ALU
  function automatic int resolve_order(input int k);
    case (k)
      0: return int'(CAT_BRANCH);
      1: return int'(CAT_SALU);
      2: return int'(CAT_VMEM);
      3: return int'(CAT_SCRATCH);
      default: return int'(CAT_VALU);
    endcase
  endfunction
endpackage

// File: rtl/simd_rotor.sv
module simd_rotor #(
  parameter int NUM_SIMD = 4,
  localparam int SW = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] sel
);
  localparam logic [SW-1:0] LAST = SW'(NUM_SIMD - 1);

  always_ff @(posedge clk) begin
    if (rst)               sel <= '0;
    else if (sel == LAST)  sel <= '0;
    else                   sel <= sel + 1'b1;
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] start,
  output logic [N-1:0]  grant,
  output logic [PW-1:0] win,
  output logic          hit
);
  always_comb begin
    int idx;
    grant = '0;
    win   = '0;
    hit   = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = int'(start) + i;
      if (idx >= N) idx = idx - N;
      if (!hit && req[idx]) begin
        hit        = 1'b1;
        grant[idx] = 1'b1;
        win        = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_SIMD       = 4,
  parameter int WAVES_PER_SIMD = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_SIMD*WAVES_PER_SIMD-1:0]  slot_valid,
  input  logic [NUM_SIMD*WAVES_PER_SIMD-1:0]  slot_ready,
  input  logic [3*NUM_SIMD*WAVES_PER_SIMD-1:0] slot_cat,
  input  logic [4:0]                          cat_busy,
  output logic [NUM_SIMD*WAVES_PER_SIMD-1:0]  issue_grant,
  output logic [4:0]                          cat_issue
);
  localparam int W  = WAVES_PER_SIMD;
  localparam int NW = NUM_SIMD * W;
  localparam int SW = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1;
  localparam int WW = (W > 1) ? $clog2(W) : 1;

  logic [SW-1:0]   simd_sel;
  logic [W-1:0]    loc_elig;
  logic [CAT_W-1:0] loc_cat [W];
  logic [W-1:0]    int_grant;
  logic [W-1:0]    loc_grant;
  logic [NW-1:0]   next_grant;
  logic [NUM_CAT:0][W-1:0]       taken;
  logic [NUM_CAT-1:0]            hit_by_cat;
  logic [NUM_CAT-1:0][WW-1:0]    win_by_cat;
  logic [WW-1:0]   cat_ptr [NUM_SIMD][NUM_CAT];

  simd_rotor #(.NUM_SIMD(NUM_SIMD)) u_rotor (
    .clk(clk), .rst(rst), .sel(simd_sel)
  );

  // View of the focused SIMD's slots
  always_comb begin
    int base;
    base = int'(simd_sel) * W;
    for (int j = 0; j < W; j++) begin
      loc_elig[j]  = slot_valid[base + j] & slot_ready[base + j];
      loc_cat[j]   = slot_cat[(base + j)*CAT_W +: CAT_W];
      int_grant[j] = loc_elig[j] && (loc_cat[j] == CAT_INTERNAL);
    end
  end

  assign taken[0] = '0;

  generate
    for (genvar k = 0; k < NUM_CAT; k++) begin : g_cat
      localparam int C = resolve_order(k);
      logic [W-1:0]  req;
      logic [W-1:0]  gnt;
      logic [WW-1:0] win;
      logic          hit;

      always_comb begin
        for (int j = 0; j < W; j++)
          req[j] = loc_elig[j] && (loc_cat[j] == CAT_W'(C)) && !taken[k][j] && !cat_busy[C];
      end

      rr_pick #(.N(W)) u_pick (
        .req(req), .start(cat_ptr[simd_sel][C]), .grant(gnt), .win(win), .hit(hit)
      );

      assign taken[k+1]    = taken[k] | gnt;
      assign hit_by_cat[C] = hit;
      assign win_by_cat[C] = win;
    end
  endgenerate

  assign loc_grant = taken[NUM_CAT] | int_grant;

  always_comb begin
    next_grant = '0;
    next_grant[int'(simd_sel)*W +: W] = loc_grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_grant <= '0;
      cat_issue   <= '0;
      for (int s = 0; s < NUM_SIMD; s++)
        for (int c = 0; c < NUM_CAT; c++)
          cat_ptr[s][c] <= '0;
    end else begin
      issue_grant <= next_grant;
      cat_issue   <= hit_by_cat;
      for (int c = 0; c < NUM_CAT; c++)
        if (hit_by_cat[c])
          cat_ptr[simd_sel][c] <= (win_by_cat[c] == WW'(W-1)) ? '0 : win_by_cat[c] + 1'b1;
    end
  end

  // Checks
  logic primed;
  always_ff @(posedge clk) primed <= !rst;

  function automatic logic [NW-1:0] simd_mask(input logic [SW-1:0] s);
    logic [NW-1:0] m;
    m = '0;
    m[int'(s)*W +: W] = '1;
    return m;
  endfunction

  assert_one_simd_R2: assert property (@(posedge clk) disable iff (rst || !primed)
    (issue_grant & ~simd_mask($past(simd_sel))) == '0);

  assert_rotate_R2: assert property (@(posedge clk) disable iff (rst || !primed)
    simd_sel == (($past(simd_sel) == SW'(NUM_SIMD-1)) ? '0 : $past(simd_sel) + 1'b1));

  assert_eligible_R3: assert property (@(posedge clk) disable iff (rst || !primed)
    (issue_grant & ~$past(slot_valid & slot_ready)) == '0);

  assert_busy_R6: assert property (@(posedge clk) disable iff (rst || !primed)
    (cat_issue & $past(cat_busy)) == '0);

  assert_count_R4: assert property (@(posedge clk) disable iff (rst || !primed)
    $countones(issue_grant) >= $countones(cat_issue));
endmodule

// File: tb/sim_wave_issue_sched.sv
`timescale 1ns/1ps
module sim_wave_issue_sched;
  localparam int NS = 4;
  localparam int W  = 8;
  localparam int NW = NS * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]   v, r;
  logic [3*NW-1:0] cat;
  logic [4:0]      busy;
  logic [NW-1:0]   issue_grant;
  logic [4:0]      cat_issue;

  int n_tests = 0;
  int n_fail  = 0;
  int msim;
  int mptr [NS][5];

  always #2 clk = ~clk;

  wave_issue_sched #(.NUM_SIMD(NS), .WAVES_PER_SIMD(W)) u0 (
    .clk(clk), .rst(rst), .slot_valid(v), .slot_ready(r), .slot_cat(cat),
    .cat_busy(busy), .issue_grant(issue_grant), .cat_issue(cat_issue)
  );

  typedef struct packed {
    logic [31:0] v;
    logic [31:0] r;
    logic [4:0]  b;
    logic [7:0]  seed;
  } stim_t;

  localparam stim_t TBL [12] = '{
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b00000, 8'd0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b00000, 8'd1},
    '{32'hF0F0_F0F0, 32'hFFFF_FFFF, 5'b00000, 8'd2},
    '{32'hFFFF_FFFF, 32'h0F0F_0F0F, 5'b00101, 8'd3},
    '{32'hAAAA_5555, 32'hFFFF_0000, 5'b00000, 8'd4},
    '{32'h1234_5678, 32'h8765_4321, 5'b10000, 8'd5},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b01010, 8'd6},
    '{32'h0000_0000, 32'hFFFF_FFFF, 5'b00000, 8'd7},
    '{32'hFFFF_FFFF, 32'h0000_0000, 5'b00000, 8'd0},
    '{32'hDEAD_BEEF, 32'hFEED_FACE, 5'b00000, 8'd2},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b11111, 8'd3},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b00000, 8'd4}
  };

  function automatic logic [3*NW-1:0] mk_cat(input int seed);
    logic [3*NW-1:0] c;
    for (int i = 0; i < NW; i++) c[i*3 +: 3] = 3'((i*3 + seed) % 8);
    return c;
  endfunction

  function automatic logic [3*NW-1:0] fill_cat(input logic [2:0] code);
    logic [3*NW-1:0] c;
    for (int i = 0; i < NW; i++) c[i*3 +: 3] = code;
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    msim = 0;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < 5; c++) mptr[s][c] = 0;
  endtask

  // Reference: independent scan per category from stored pointer
  task automatic model(output logic [NW-1:0] g, output logic [4:0] cv);
    g  = '0;
    cv = '0;
    for (int j = 0; j < W; j++) begin
      int idx = msim*W + j;
      if (v[idx] && r[idx] && cat[idx*3 +: 3] == 3'd5) g[idx] = 1'b1;
    end
    for (int c = 0; c < 5; c++) begin
      if (!busy[c]) begin
        for (int j = 0; j < W; j++) begin
          int k = (mptr[msim][c] + j) % W;
          int idx = msim*W + k;
          if (!cv[c] && v[idx] && r[idx] && cat[idx*3 +: 3] == 3'(c)) begin
            cv[c] = 1'b1;
            g[idx] = 1'b1;
            mptr[msim][c] = (k + 1) % W;
          end
        end
      end
    end
  endtask

  function automatic logic [NW-1:0] code_mask(input logic [3*NW-1:0] c, input logic [2:0] a, input logic [2:0] b);
    logic [NW-1:0] m;
    for (int i = 0; i < NW; i++) m[i] = (c[i*3 +: 3] == a) || (c[i*3 +: 3] == b);
    return m;
  endfunction

  task automatic step(input string tag);
    logic [NW-1:0] eg;
    logic [4:0]    ec;
    logic [NW-1:0] m67;
    model(eg, ec);
    m67 = code_mask(cat, 3'd6, 3'd7);
    @(posedge clk);
    #1;
    check(tag, issue_grant, eg);
    check("R4 cat_issue", {27'd0, cat_issue}, {27'd0, ec});
    check("R8 unused codes", issue_grant & m67, '0);
    msim = (msim + 1) % NS;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    v = '0; r = '0; cat = '0; busy = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset grant", issue_grant, '0);
    check("R1 reset strobe", {27'd0, cat_issue}, '0);
    rst = 1'b0;

    // Table walk: mixed patterns, busy, internal, unused codes
    for (int t = 0; t < 12; t++) begin
      v = TBL[t].v; r = TBL[t].r; busy = TBL[t].b; cat = mk_cat(int'(TBL[t].seed));
      step("R2/R3/R5/R6/R7 table");
    end

    // R5: one category on every slot, pointers walk per SIMD
    v = '1; r = '1; busy = '0; cat = fill_cat(3'd0);
    for (int i = 0; i < 20; i++) step("R5 rotating pointer");

    // R6 and R7: all busy, internals only
    busy = 5'b11111; cat = mk_cat(5);
    for (int i = 0; i < 4; i++) step("R6/R7 busy with internals");
    busy = '0; cat = fill_cat(3'd5);
    for (int i = 0; i < 4; i++) step("R7 all internal");

    // R8: unused codes only
    cat = mk_cat(6);
    for (int i = 0; i < NW; i++) cat[i*3 +: 3] = (i % 2) ? 3'd6 : 3'd7;
    step("R8 only unused codes");
    check("R8 no grant", issue_grant, '0);

    // R9: five categories plus internal on one cycle
    for (int i = 0; i < NW; i++) cat[i*3 +: 3] = 3'(i % W % 6);
    step("R9 full issue");
    check("R9 strobes", {27'd0, cat_issue}, 32'h1F);
    check("R9 grant count", $countones(issue_grant), 6);

    // R1: reset in mid-run restarts rotation and pointers
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset grant", issue_grant, '0);
    model_reset();
    rst = 1'b0;
    cat = fill_cat(3'd0); v = '1; r = '1; busy = '0;
    step("R1 after reset");
    check("R1 slot0 of SIMD0", issue_grant, 32'h0000_0001);
    step("R2 second SIMD");
    check("R2 slot0 of SIMD1", issue_grant, 32'h0000_0100);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule